// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets software run a single clause-22 management transaction toward an external PHY. Software first loads a 16-bit data register (for writes), then writes a command register that names the PHY address, the PHY register and the transfer direction. The write starts the transaction. The controller generates the management clock from the system clock, shifts out a preamble, the start and opcode fields and the two address fields, then either drives the turnaround and the write data or releases the data line and captures sixteen bits from the PHY.

While a transaction runs, bit 0 of the command register reads as 1. It drops by itself when the last bit period ends. Captured read data is then found in the data register. Writes to either register while a transaction is running have no effect, so a command cannot be corrupted in flight.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: The command register (`reg_sel_i`=0) holds the PHY address in bits 15:11, the register number in bits 10:6 and the direction in bit 1 (1 = write, 0 = read). Bit 0 reads the busy flag. Bits 5:2 read 0.
- R3: A command write while idle starts a transaction. Busy reads 1 from the next cycle on, for exactly `64*CLK_DIV` cycles, then clears by itself.
- R4: While busy, `mdc_o` has a period of `CLK_DIV` system cycles and shows exactly 64 rising edges per transaction. `mdc_o` stays low while idle.
- R5: The bits presented at successive rising edges of `mdc_o` are as follows, each field MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), the 5-bit PHY address, then the 5-bit register number.
- R6: For a read, `mdio_oe_o` is low for the last 18 bit periods (the turnaround plus the data). The controller samples `mdio_i` at the 16 data rising edges, MSB first, and at completion puts the result in data register bits 15:0.
- R7: For a write, the turnaround is driven as `10` and is followed by the data register contents that were present at the start. The data register is unchanged afterwards.
- R8: A command write or a data write issued while busy is ignored. The frame in flight, the command fields and the data register contents are unaffected.
- R9: At the end of a transaction, `mdio_oe_o` and `mdc_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 command, 1 data |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the PHY |
| mdio_o | output | 1 | Management data toward the PHY |
| mdio_oe_o | output | 1 | Drive enable for `mdio_o` |

## Verification
The assertions assume that `CLK_DIV` is even and at least 4, and that `mdio_i` is only meaningful while the controller has released the line. The stimulus draws PHY addresses, register numbers, directions, write data and PHY reply words at random, from a fixed seed. Directed cases cover all-zero and all-one fields and a pair of register writes issued in the middle of a transaction. A PHY model changes `mdio_i` only on falling edges of `mdc_o`, so its data is stable at every rising edge where it is sampled.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  localparam logic [1:0] START_SEQ = 2'b01;
  localparam logic [1:0] TA_DRIVE  = 2'b10;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic              wr;
  } mgmt_cmd_t;
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the clock level only moves at a half-period boundary
  assert_mdc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !rise_o && !fall_o |=> $stable(mdc_o) || !run_i);
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mgmt_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned FRAME_LEN = PRE_LEN + 32;
  localparam int unsigned TA_IDX    = PRE_LEN + 14;
  localparam int unsigned DATA_IDX  = TA_IDX + 2;
  localparam int unsigned BW        = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] frame_q;
  logic [BW-1:0]        bit_q;
  logic                 busy_q;
  logic                 wr_q;
  logic [DATA_W-1:0]    rsh_q;
  logic                 last;
  logic [1:0]           op;
  logic [1:0]           ta;
  logic [DATA_W-1:0]    wd;

  assign op   = cmd_i.wr ? OP_WRITE : OP_READ;
  assign ta   = cmd_i.wr ? TA_DRIVE : 2'b00;
  assign wd   = cmd_i.wr ? wdata_i : '0;
  assign last = (bit_q == BW'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        frame_q <= {{PRE_LEN{1'b1}}, START_SEQ, op, cmd_i.phy, cmd_i.regad, ta, wd};
        bit_q   <= '0;
        busy_q  <= 1'b1;
        wr_q    <= cmd_i.wr;
      end
    end else if (fall_i) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        bit_q   <= bit_q + 1'b1;
        frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  // sample on the cycle the management clock rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsh_q <= '0;
    end else if (busy_q && rise_i && !wr_q && bit_q >= BW'(DATA_IDX)) begin
      rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last;
  assign mdio_o    = busy_q && frame_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && (wr_q || bit_q < BW'(TA_IDX));
  assign rdata_o   = rsh_q;

  // R5: the preamble is driven as ones
  assert_preamble_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && bit_q < BW'(PRE_LEN) |-> mdio_oe_o && mdio_o);

  // R9: the line is released whenever no frame is running
  assert_idle_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdio_oe_o);

  // R4: one bit period per falling edge of the management clock
  assert_bit_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fall_i |=> $stable(bit_q));
endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  mgmt_cmd_t         cmd_q;
  mgmt_cmd_t         cmd_in;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] eng_rdata;
  logic              busy;
  logic              done;
  logic              rise;
  logic              fall;
  logic              accept_cmd;
  logic              accept_data;
  logic              unused_wbits;

  assign cmd_in.phy   = reg_wdata_i[15:11];
  assign cmd_in.regad = reg_wdata_i[10:6];
  assign cmd_in.wr    = reg_wdata_i[1];
  assign unused_wbits = ^{reg_wdata_i[5:2], reg_wdata_i[0]};

  assign accept_cmd  = reg_we_i && !reg_sel_i && !busy;
  assign accept_data = reg_we_i && reg_sel_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept_cmd) cmd_q <= cmd_in;
      if (accept_data) data_q <= reg_wdata_i;
      else if (done && !cmd_q.wr) data_q <= eng_rdata;
    end
  end

  assign reg_rdata_o = reg_sel_i ? data_q
                                 : {cmd_q.phy, cmd_q.regad, 4'b0000, cmd_q.wr, busy};

  mii_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mii_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept_cmd),
    .cmd_i     (cmd_in),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (eng_rdata)
  );

  // R3: an accepted command raises busy on the next cycle
  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_cmd |=> busy);

  // R8: command writes during a transaction leave the fields alone
  assert_cmd_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i && busy |=> $stable(cmd_q));

  // R8: data writes during a transaction are dropped unless read data lands
  assert_data_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i && busy && !done |=> $stable(data_q));

  // R4: no management clock while idle
  assert_mdc_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
endmodule

// File: tb/tb_mii_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mii_mgmt_ctrl;
  localparam int CLK_DIV = 8;
  localparam int PRE_LEN = 32;
  localparam int FLEN    = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        mdc_o;
  logic        mdio_i = 1'b0;
  logic        mdio_o;
  logic        mdio_oe_o;

  int checks = 0;
  int errors = 0;

  logic [FLEN-1:0] cap_bits;
  logic [FLEN-1:0] cap_oe;
  int              rise_cnt = 0;
  logic [15:0]     phy_val = '0;

  always #4 clk = ~clk;

  mii_mgmt_ctrl #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  // line observer
  always @(posedge mdc_o) begin
    if (rise_cnt < FLEN) begin
      cap_bits[FLEN-1-rise_cnt] = mdio_o;
      cap_oe[FLEN-1-rise_cnt]   = mdio_oe_o;
    end
    rise_cnt = rise_cnt + 1;
  end

  // PHY model: updates its reply bit after each falling edge
  always @(negedge mdc_o) begin
    if (rise_cnt >= 48 && rise_cnt < FLEN) mdio_i = phy_val[63-rise_cnt];
    else mdio_i = 1'b0;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FLEN-1:0] exp_frame(input logic wr, input logic [4:0] phy,
                                               input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
            (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
  endfunction

  function automatic logic [FLEN-1:0] exp_oe(input logic wr);
    return wr ? {FLEN{1'b1}} : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic reg_write(input logic sel, input logic [15:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_sel_i = 1'b0;
  endtask

  task automatic run_op(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] pv, input logic poke);
    int   busy_n;
    int   cyc;
    logic fin;
    logic [FLEN-1:0] ef;
    logic [FLEN-1:0] em;
    logic [15:0] cmdw;
    cmdw = {phy, ra, 4'b0000, wr, 1'b0};
    reg_write(1'b1, wd);
    phy_val = pv;
    rise_cnt = 0;
    reg_write(1'b0, cmdw);
    busy_n = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 4000) begin
      if (reg_sel_i || reg_rdata_o[0]) busy_n++;
      else fin = 1'b1;
      if (poke && cyc == 100) begin
        reg_we_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = ~cmdw;
      end
      if (poke && cyc == 101) begin
        reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = ~wd;
      end
      if (cyc == 102) begin
        reg_we_i = 1'b0; reg_sel_i = 1'b0;
      end
      if (!fin) @(negedge clk);
      cyc++;
    end
    ef = exp_frame(wr, phy, ra, wd);
    em = exp_oe(wr);
    chk(busy_n == FLEN*CLK_DIV, "R3 busy duration", 64'(busy_n), 64'(FLEN*CLK_DIV));
    chk(rise_cnt == FLEN, "R4 mdc rising edges", 64'(rise_cnt), 64'(FLEN));
    chk(cap_oe == em, wr ? "R7 write drive enable" : "R6 read release", cap_oe, em);
    chk((cap_bits & em) == (ef & em), poke ? "R8 frame after poke" : "R5 frame bits",
        cap_bits & em, ef & em);
    chk(!mdc_o && !mdio_oe_o, "R9 idle after frame", {62'h0, mdc_o, mdio_oe_o}, 64'h0);
    reg_sel_i = 1'b0; #1;
    chk(reg_rdata_o == cmdw, poke ? "R8 command fields" : "R2 command readback",
        64'(reg_rdata_o), 64'(cmdw));
    reg_sel_i = 1'b1; #1;
    chk(reg_rdata_o == (wr ? wd : pv), wr ? "R7 data kept" : "R6 read data",
        64'(reg_rdata_o), 64'(wr ? wd : pv));
    reg_sel_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    reg_sel_i = 1'b0; #1;
    chk(reg_rdata_o == 16'h0, "R1 command reset", 64'(reg_rdata_o), 64'h0);
    reg_sel_i = 1'b1; #1;
    chk(reg_rdata_o == 16'h0, "R1 data reset", 64'(reg_rdata_o), 64'h0);
    reg_sel_i = 1'b0;
    chk(!mdc_o && !mdio_oe_o, "R1 line idle", {62'h0, mdc_o, mdio_oe_o}, 64'h0);
    @(negedge clk);

    run_op(1'b0, 5'd0,  5'd0,  16'h1234, 16'hBEEF, 1'b0);
    run_op(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
    run_op(1'b0, 5'd31, 5'd31, 16'hAAAA, 16'h0000, 1'b0);
    run_op(1'b1, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 1'b0);
    run_op(1'b0, 5'd5,  5'd17, 16'h0F0F, 16'hFFFF, 1'b1);
    run_op(1'b1, 5'd9,  5'd3,  16'hC35A, 16'h0000, 1'b1);
    for (int i = 0; i < 8; i++) begin
      run_op(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule